// File: doc/BRIEF.md
# I2C Slave Receive Engine with Status-Gated Acknowledge

This block is the receive half of an I2C slave port. It watches the open-drain clock and data lines and detects START and STOP. After a START it shifts in eight bits, one on each clock rising edge. It compares the address byte with a programmable address register and copies each accepted byte into a one-byte receive buffer. The acknowledge is not automatic. The engine pulls SDA low for the ninth clock only when the byte is addressed to it and the buffer is empty and no overflow is pending. The interrupt flag is raised on the falling edge of the ninth clock whether or not the acknowledge was given.

Both 7-bit and 10-bit addressing are supported. For 10-bit addresses, software helps with the match. After each address byte is accepted, the engine raises an update-address flag and holds SCL low until software rewrites the address register. After a repeated START within the same transfer, only the high address byte has to match again.

The control state machine has six states:
- `RX_IDLE`: waits for a START.
- `RX_ADDR_HI`: first or only address byte.
- `RX_ADDR_LO`: second 10-bit address byte.
- `RX_DATA`: data bytes.
- `RX_STRETCH`: SCL is held low while waiting for an address write.
- `RX_SKIP`: waits for the next START or STOP.

The transitions are:
- From any state, a STOP leads to `RX_IDLE` and a START leads to `RX_ADDR_HI`.
- In a receive state, an address mismatch at the eighth falling edge leads to `RX_SKIP`.
- At the ninth falling edge, a receive state moves to the state chosen at the eighth edge. That state is `RX_DATA`, `RX_ADDR_LO`, `RX_STRETCH` or `RX_SKIP`.
- From `RX_STRETCH`, an address-register write leads to the state that was saved when the stretch began.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset all flags, the buffer and the address register are zero, and both pull-low enables are released.
- R2: In 7-bit mode (mode10 = 0), bits 7:1 of the first byte after a START are compared with bits 7:1 of the address register; bit 0 (R/W) is not compared. On a match with the buffer empty and no overflow, the byte is loaded into the buffer, buf_full is set, and sda_pull is asserted from the eighth SCL falling edge until the ninth.
- R3: An address byte that does not match gets no acknowledge and no interrupt. The engine then ignores the bus until the next START.
- R4: Data bytes that follow an accepted address are acknowledged and loaded under the same rule. irq is set at the ninth SCL falling edge and is cleared by a pulse on irq_clr.
- R5: If buf_full or ovf is set when an addressed byte completes, the buffer is not loaded and no acknowledge is driven, but irq is still set.
- R6: An addressed byte that arrives while buf_full is set sets ovf. If ovf alone is set, it keeps its value. Only an ovf_clr pulse clears it.
- R7: A buf_re pulse clears buf_full.
- R8: In 10-bit mode (mode10 = 1), a first byte is accepted only if it has the form 11110 A9 A8 0, with bits 7:1 equal to address register bits 7:1. A byte with R/W = 1 or with another prefix is refused while no full 10-bit match is in place.
- R9: After each accepted 10-bit address byte, upd_adr and irq are set and scl_pull holds SCL low. An adr_we write clears upd_adr and releases SCL.
- R10: The second 10-bit address byte is compared with all eight bits of the address register.
- R11: After a repeated START that follows a complete 10-bit match, a matching high byte alone is accepted. upd_adr is not set and SCL is not stretched.
- R12: A STOP returns the engine to idle and forgets the 10-bit match, so the next high byte again starts the two-phase sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| adr_we | input | 1 | Address register write strobe; clears upd_adr |
| adr_wdata | input | 8 | Address register write data |
| buf_re | input | 1 | Buffer read strobe; clears buf_full |
| buf_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf_clr | input | 1 | Clears ovf |
| ovf | output | 1 | Overflow flag |
| irq_clr | input | 1 | Clears irq |
| irq | output | 1 | Interrupt flag |
| upd_adr | output | 1 | Software must rewrite the address register |

## Verification
The bench goes after the acknowledge gate.
- It fills the buffer and then sends another byte. A design that acknowledged on address match alone would drive SDA and overwrite the buffer.
- It leaves only the overflow flag set. A design that cleared overflow on a buffer read, or gated only on buf_full, would acknowledge again.
- It checks that the R/W bit takes no part in the 7-bit compare, and that the second 10-bit byte is compared on all eight bits.
- It runs the two-phase 10-bit match with a repeated START and then a fresh START. A design that forgot the match at STOP, or kept it, would stretch SCL where it must not, or skip a stretch it must make, and the bench would see the line hang or the flag stay clear.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    localparam int BYTE_W = 8;

    // upper five bits of a 10-bit high address byte
    localparam logic [4:0] TENBIT_TAG = 5'b11110;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR_HI,
        RX_ADDR_LO,
        RX_DATA,
        RX_STRETCH,
        RX_SKIP
    } rx_state_t;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;
    logic             scl_s;
    logic             scl_d;
    logic             sda_d;

    assign pins = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], pins[g]};
                end
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];
    assign scl_d = prev[0];
    assign sda_d = prev[1];

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_bit_shift.sv
module i2c_bit_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [BYTE_W-1:0] sr,
    output logic              decide,
    output logic              fin
);

    localparam int CW = $clog2(BYTE_W + 2);
    localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W);
    localparam logic [CW-1:0] CNT_ACK  = CW'(BYTE_W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sr  <= '0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else if (scl_rise) begin
            if (cnt < CNT_LAST) begin
                sr  <= {sr[BYTE_W-2:0], sda_s};
                cnt <= cnt + 1'b1;
            end else if (cnt == CNT_LAST) begin
                cnt <= CNT_ACK;
            end
        end else if (scl_fall && cnt == CNT_ACK) begin
            cnt <= '0;
        end
    end

    // eighth falling edge: byte complete; ninth: acknowledge slot ends
    assign decide = scl_fall && (cnt == CNT_LAST);
    assign fin    = scl_fall && (cnt == CNT_ACK);

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode10,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              decide,
    input  logic              fin,
    input  logic [BYTE_W-1:0] sr,
    input  logic              adr_we,
    input  logic [BYTE_W-1:0] adr_wdata,
    input  logic              buf_re,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] buf_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              upd_adr,
    output logic              scl_pull,
    output logic              sda_pull
);

    rx_state_t         state, state_n, pend_nxt, resume_q, after_c;
    logic [BYTE_W-1:0] adr_q;
    logic              ten_done;
    logic              pend_hit, pend_ua, ack_q;
    logic              hit_c, ua_c, acc_c, in_rx, hi_ok;

    assign in_rx = (state == RX_ADDR_HI) || (state == RX_ADDR_LO) || (state == RX_DATA);
    assign hi_ok = (sr[7:3] == TENBIT_TAG) && (sr[7:1] == adr_q[7:1]);

    // byte classification at the eighth falling edge
    always_comb begin
        hit_c   = 1'b0;
        ua_c    = 1'b0;
        after_c = RX_SKIP;
        unique case (state)
            RX_ADDR_HI: begin
                if (!mode10) begin
                    hit_c   = (sr[7:1] == adr_q[7:1]);
                    after_c = sr[0] ? RX_SKIP : RX_DATA;
                end else if (ten_done) begin
                    hit_c   = hi_ok;
                    after_c = sr[0] ? RX_SKIP : RX_DATA;
                end else begin
                    hit_c   = hi_ok && !sr[0];
                    ua_c    = 1'b1;
                    after_c = RX_ADDR_LO;
                end
            end
            RX_ADDR_LO: begin
                hit_c   = (sr == adr_q);
                ua_c    = 1'b1;
                after_c = RX_DATA;
            end
            RX_DATA: begin
                hit_c   = 1'b1;
                after_c = RX_DATA;
            end
            default: begin
                hit_c = 1'b0;
            end
        endcase
        acc_c = hit_c && !buf_full && !ovf;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = RX_IDLE;
        end else if (start_det) begin
            state_n = RX_ADDR_HI;
        end else begin
            unique case (state)
                RX_ADDR_HI, RX_ADDR_LO, RX_DATA: begin
                    if (decide && !hit_c) begin
                        state_n = RX_SKIP;
                    end else if (fin && pend_hit) begin
                        state_n = pend_nxt;
                    end
                end
                RX_STRETCH: begin
                    if (adr_we) begin
                        state_n = resume_q;
                    end
                end
                default: begin
                    state_n = state;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // datapath and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_q    <= '0;
            ten_done <= 1'b0;
            pend_hit <= 1'b0;
            pend_ua  <= 1'b0;
            ack_q    <= 1'b0;
            pend_nxt <= RX_IDLE;
            resume_q <= RX_IDLE;
            buf_data <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
            upd_adr  <= 1'b0;
        end else begin
            if (adr_we) begin
                adr_q <= adr_wdata;
            end

            if (start_det || stop_det) begin
                pend_hit <= 1'b0;
                pend_ua  <= 1'b0;
                ack_q    <= 1'b0;
            end else if (decide && in_rx) begin
                pend_hit <= hit_c;
                pend_ua  <= ua_c && acc_c;
                ack_q    <= acc_c;
                resume_q <= after_c;
                if (ua_c && acc_c) begin
                    pend_nxt <= RX_STRETCH;
                end else if (acc_c) begin
                    pend_nxt <= after_c;
                end else begin
                    pend_nxt <= RX_SKIP;
                end
            end else if (fin) begin
                pend_hit <= 1'b0;
                pend_ua  <= 1'b0;
                ack_q    <= 1'b0;
            end

            if (stop_det) begin
                ten_done <= 1'b0;
            end else if (decide && state == RX_ADDR_LO && acc_c) begin
                ten_done <= 1'b1;
            end

            if (decide && in_rx && acc_c) begin
                buf_data <= sr;
            end

            if (decide && in_rx && acc_c) begin
                buf_full <= 1'b1;
            end else if (buf_re) begin
                buf_full <= 1'b0;
            end

            if (decide && in_rx && hit_c && buf_full) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end

            if (fin && pend_hit) begin
                irq <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end

            if (fin && pend_ua) begin
                upd_adr <= 1'b1;
            end else if (adr_we) begin
                upd_adr <= 1'b0;
            end
        end
    end

    // pin outputs
    always_comb begin
        sda_pull = ack_q;
        scl_pull = (state == RX_STRETCH);
    end

    AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && in_rx && (buf_full || ovf)) |=> !sda_pull); // R5
    AST_ACK_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> in_rx); // R3
    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_data) |-> buf_full); // R2
    AST_IRQ_AT_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fin)); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R6
    AST_STRETCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> upd_adr); // R9

endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode10,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       adr_we,
    input  logic [7:0] adr_wdata,
    input  logic       buf_re,
    output logic [7:0] buf_data,
    output logic       buf_full,
    input  logic       ovf_clr,
    output logic       ovf,
    input  logic       irq_clr,
    output logic       irq,
    output logic       upd_adr
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              decide, fin;
    logic [BYTE_W-1:0] sr;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bit_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sr        (sr),
        .decide    (decide),
        .fin       (fin)
    );

    i2c_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode10    (mode10),
        .start_det (start_det),
        .stop_det  (stop_det),
        .decide    (decide),
        .fin       (fin),
        .sr        (sr),
        .adr_we    (adr_we),
        .adr_wdata (adr_wdata),
        .buf_re    (buf_re),
        .ovf_clr   (ovf_clr),
        .irq_clr   (irq_clr),
        .buf_data  (buf_data),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq),
        .upd_adr   (upd_adr),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

endmodule

// File: tb/sim_i2c_rx_slave.sv
module sim_i2c_rx_slave;

    localparam int HP = 10;
    localparam int WD_LIMIT = 150000;
    localparam int NVEC = 7;
    // {address register, byte on the bus, acknowledge expected}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h84, 8'h84, 1'b1},
        {8'h84, 8'h85, 1'b1},
        {8'h84, 8'h86, 1'b0},
        {8'hA0, 8'hA1, 1'b1},
        {8'hA0, 8'h20, 1'b0},
        {8'hFE, 8'hFF, 1'b1},
        {8'h01, 8'h00, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode10 = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       adr_we = 1'b0;
    logic [7:0] adr_wdata = 8'h00;
    logic       buf_re = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       scl_pull, sda_pull, buf_full, ovf, irq, upd_adr;
    logic [7:0] buf_data;
    logic       scl_line, sda_line;
    logic       ackv;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    i2c_rx_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode10    (mode10),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .adr_we    (adr_we),
        .adr_wdata (adr_wdata),
        .buf_re    (buf_re),
        .buf_data  (buf_data),
        .buf_full  (buf_full),
        .ovf_clr   (ovf_clr),
        .ovf       (ovf),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .upd_adr   (upd_adr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic pulse_adr(input logic [7:0] v);
        adr_wdata = v;
        adr_we = 1'b1;
        wait_clk(1);
        adr_we = 1'b0;
        wait_clk(2);
    endtask

    task automatic pulse_read();
        buf_re = 1'b1;
        wait_clk(1);
        buf_re = 1'b0;
        wait_clk(1);
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1;
        wait_clk(1);
        irq_clr = 1'b0;
        wait_clk(1);
    endtask

    task automatic pulse_ovf_clr();
        ovf_clr = 1'b1;
        wait_clk(1);
        ovf_clr = 1'b0;
        wait_clk(1);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(HP);
        scl_m = 1'b1;
        wait_scl_high();
        wait_clk(HP);
        sda_m = 1'b0;
        wait_clk(HP);
        scl_m = 1'b0;
        wait_clk(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(HP);
        scl_m = 1'b1;
        wait_scl_high();
        wait_clk(HP);
        sda_m = 1'b1;
        wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_clk(HP);
            scl_m = 1'b1;
            wait_scl_high();
            wait_clk(HP);
            scl_m = 1'b0;
            wait_clk(HP);
        end
        sda_m = 1'b1;
        wait_clk(HP);
        scl_m = 1'b1;
        wait_scl_high();
        wait_clk(HP / 2);
        ack = ~sda_line;
        wait_clk(HP / 2);
        scl_m = 1'b0;
        wait_clk(HP);
    endtask

    initial begin
        wait_clk(4);
        // R1: reset state
        check("R1 buf_full", buf_full, 0);
        check("R1 ovf", ovf, 0);
        check("R1 irq", irq, 0);
        check("R1 upd_adr", upd_adr, 0);
        check("R1 pulls", {scl_pull, sda_pull}, 0);
        check("R1 buf_data", buf_data, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // table walk, 7-bit mode: R2 match, R3 mismatch
        for (int v = 0; v < NVEC; v++) begin
            pulse_adr(VEC[v][16:9]);
            bus_start();
            send_byte(VEC[v][8:1], ackv);
            check(VEC[v][0] ? "R2 ack" : "R3 nack", ackv, VEC[v][0]);
            check("R2 full", buf_full, VEC[v][0]);
            check("R3 irq", irq, VEC[v][0]);
            if (VEC[v][0]) check("R2 buf", buf_data, VEC[v][8:1]);
            check("R2 sda released", sda_pull, 0);
            bus_stop();
            pulse_read();
            pulse_irq_clr();
        end

        // R3: bytes after a mismatched address are ignored
        pulse_adr(8'h84);
        bus_start();
        send_byte(8'h86, ackv);
        send_byte(8'hFF, ackv);
        check("R3 data ignored ack", ackv, 0);
        check("R3 data ignored full", buf_full, 0);
        check("R3 data ignored irq", irq, 0);
        bus_stop();

        // R4 / R5 / R6 / R7: data and overflow gating
        bus_start();
        send_byte(8'h84, ackv);
        check("R2 addr ack", ackv, 1);
        pulse_read();
        check("R7 read clears full", buf_full, 0);
        pulse_irq_clr();
        check("R4 irq_clr", irq, 0);
        send_byte(8'h5A, ackv);
        check("R4 data ack", ackv, 1);
        check("R4 data buf", buf_data, 8'h5A);
        check("R4 irq", irq, 1);
        pulse_irq_clr();
        send_byte(8'h33, ackv);
        check("R5 nack when full", ackv, 0);
        check("R5 buf kept", buf_data, 8'h5A);
        check("R5 irq set", irq, 1);
        check("R6 ovf set", ovf, 1);
        bus_stop();
        pulse_read();
        check("R7 full cleared", buf_full, 0);
        pulse_irq_clr();
        bus_start();
        send_byte(8'h84, ackv);
        check("R5 nack on ovf alone", ackv, 0);
        check("R5 irq on ovf alone", irq, 1);
        check("R6 ovf kept", ovf, 1);
        check("R6 full stays clear", buf_full, 0);
        bus_stop();
        pulse_ovf_clr();
        check("R6 ovf_clr", ovf, 0);
        pulse_irq_clr();
        bus_start();
        send_byte(8'h84, ackv);
        check("R6 ack after clear", ackv, 1);
        bus_stop();
        pulse_read();
        pulse_irq_clr();

        // 10-bit mode: R8 R9 R10 R11
        mode10 = 1'b1;
        pulse_adr(8'hF6);
        bus_start();
        send_byte(8'hF6, ackv);
        check("R8 high ack", ackv, 1);
        check("R9 upd set", upd_adr, 1);
        check("R9 scl held", scl_pull, 1);
        check("R9 irq", irq, 1);
        check("R8 buf", buf_data, 8'hF6);
        pulse_read();
        pulse_irq_clr();
        pulse_adr(8'h3C);
        check("R9 upd cleared", upd_adr, 0);
        check("R9 scl released", scl_pull, 0);
        send_byte(8'h3C, ackv);
        check("R10 low ack", ackv, 1);
        check("R10 upd set", upd_adr, 1);
        check("R10 scl held", scl_pull, 1);
        pulse_read();
        pulse_irq_clr();
        pulse_adr(8'hF6);
        send_byte(8'h77, ackv);
        check("R9 data ack", ackv, 1);
        check("R9 data buf", buf_data, 8'h77);
        check("R9 no stretch on data", upd_adr, 0);
        pulse_read();
        bus_start();
        send_byte(8'hF6, ackv);
        check("R11 restart ack", ackv, 1);
        check("R11 no upd", upd_adr, 0);
        check("R11 no stretch", scl_pull, 0);
        pulse_read();
        send_byte(8'h11, ackv);
        check("R11 data after restart", buf_data, 8'h11);
        pulse_read();
        bus_stop();
        pulse_irq_clr();

        // R12: STOP forgets the 10-bit match
        bus_start();
        send_byte(8'hF6, ackv);
        check("R12 ack", ackv, 1);
        check("R12 two-phase again", upd_adr, 1);
        pulse_read();
        pulse_adr(8'h3D);
        send_byte(8'h3C, ackv);
        check("R10 low mismatch nack", ackv, 0);
        check("R10 low mismatch upd", upd_adr, 0);
        bus_stop();
        pulse_irq_clr();

        // R8: R/W = 1 and wrong prefix refused
        pulse_adr(8'hF6);
        bus_start();
        send_byte(8'hF7, ackv);
        check("R8 read bit nack", ackv, 0);
        check("R8 read bit irq", irq, 0);
        bus_stop();
        pulse_adr(8'h84);
        bus_start();
        send_byte(8'h84, ackv);
        check("R8 prefix nack", ackv, 0);
        check("R8 prefix full", buf_full, 0);
        bus_stop();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule